// File: doc/BRIEF.md
# Row-Hit-Aware DRAM Request Picker

This block holds the pending requests of one DRAM command queue, in arrival order, and chooses which one a memory controller should serve next. It also keeps a small table of which row is open in each bank. The controller reports the commands it has issued: activate, precharge and column access. The choice uses that table, together with per-bank timing and per-rank availability supplied from outside. The candidates are ranked in three tiers. First comes a request to an open row whose column command can go out without delay. Next comes a request to a closed or different row whose bank can be prepared in the background. Last comes a request to an open row that must wait for its column slot.

The readiness threshold for column commands follows the data bus. It is the bus-busy time minus the CAS latency, plus a read/write turnaround penalty when the burst direction changes. It never drops below the current time. A bank's row counts as closed after a set number of column accesses, or after a precharge, and stays closed until the next activate. On a pick, the chosen entry moves to the head of the queue, and the controller pops it from there once it has issued the request. The result is registered one cycle after the pick strobe.

Top module: `rowhit_picker`

## Requirements
- R1: After reset the queue is empty (count 0, head invalid) and done, found, index and kind are all zero.
- R2: A push appends the request at the tail, and a pop removes the head. The count follows both, and a push into a full queue is dropped unless a pop happens in the same cycle.
- R3: The column threshold is max(bus_busy − t_cas + extra, now). When bus_busy + extra is smaller than t_cas, the first term is taken as 0.
- R4: The extra term equals t_switch while rw_switch_i is high, and is 0 otherwise.
- R5: Only entries whose rank bit in rank_ready_i is 1 are eligible. With no eligible entry, or an empty queue, found is 0 and kind is 0 (none).
- R6: An entry that hits the open row of its bank, with that bank's column-allowed time ≤ threshold, is seamless (kind 1). The oldest such entry is chosen whatever entries come before it.
- R7: A row-miss entry whose bank hide-ok bit is 1 is a hidden-prep candidate (kind 2). Without a seamless entry, the oldest hidden-prep entry is chosen, even over older waiting hits.
- R8: A row hit that is not seamless is a prepped candidate (kind 3). Without seamless or hidden-prep entries, the oldest prepped entry wins over plain row misses.
- R9: When only plain row misses (kind 4) are eligible, the youngest of them is chosen.
- R10: A pick that finds an entry moves it to index 0, keeps the relative order of the others and leaves the count unchanged.
- R11: A bank's row is treated as closed after MAX_ACC column accesses since its last activate, or after a precharge, until the next activate of that bank.
- R12: done is high exactly one cycle after pick_i. Found, index and kind take the result of that pick and hold it until the next pick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Append a request |
| push_rank_i | input | RANK_W | Rank of the pushed request |
| push_bank_i | input | BANK_W | Bank within the rank |
| push_row_i | input | ROW_W | Row of the pushed request |
| pop_i | input | 1 | Remove the head entry |
| pick_i | input | 1 | Run the selection and reorder (push/pop ignored this cycle) |
| rw_switch_i | input | 1 | Next burst changes direction |
| now_i | input | TIME_W | Current time |
| bus_busy_i | input | TIME_W | Time the data bus becomes free |
| t_cas_i | input | TIME_W | CAS latency |
| t_switch_i | input | TIME_W | Read/write turnaround penalty |
| rank_ready_i | input | NUM_RANKS | Per-rank availability |
| bank_col_at_i | input | NB*TIME_W | Per-bank earliest column time, bank b at bits b*TIME_W |
| bank_hide_ok_i | input | NB | Per-bank background-preparation possible |
| act_i | input | 1 | Activate issued |
| act_bank_i | input | BI_W | Global bank {rank,bank} of the activate |
| act_row_i | input | ROW_W | Row activated |
| col_i | input | 1 | Column access issued |
| col_bank_i | input | BI_W | Global bank of the column access |
| pre_i | input | 1 | Precharge issued |
| pre_bank_i | input | BI_W | Global bank of the precharge |
| count_o | output | CNT_W | Number of queued entries |
| head_valid_o | output | 1 | Queue not empty |
| head_rank_o | output | RANK_W | Rank of the head entry |
| head_bank_o | output | BANK_W | Bank of the head entry |
| head_row_o | output | ROW_W | Row of the head entry |
| done_o | output | 1 | Pick result valid this cycle |
| found_o | output | 1 | Last pick found an entry |
| sel_o | output | IDX_W | Queue index chosen by the last pick |
| kind_o | output | 3 | 0 none, 1 seamless, 2 hidden, 3 prepped, 4 plain miss |

## Verification
The bench sets column-allowed times exactly at the threshold and one above it. A comparison on the wrong side then turns a seamless hit into a prepped one. It also drives the bus-busy time below the CAS latency, where an unguarded subtraction wraps and blocks every hit. Queues that mix tiers, with a hidden-prep entry behind a prepped hit and two hidden entries in a row, catch a design that lets the younger candidate win or that ranks prepped above hidden. A design that wrongly lets the oldest plain miss win is caught the same way. The pop order after a pick exposes a reorder that loses the order of the other entries. A design that forgets its column-access count, or misses the precharge close, would keep calling a closed row a hit.

// File: rtl/rhp_pkg.sv
// Shared definitions for the row-hit-aware request picker.
package rhp_pkg;
    typedef enum logic [2:0] {
        K_NONE     = 3'd0,
        K_SEAMLESS = 3'd1,
        K_HIDDEN   = 3'd2,
        K_PREPPED  = 3'd3,
        K_MISS     = 3'd4
    } pick_kind_e;
endpackage

// File: rtl/rhp_queue.sv
// Age-ordered request queue. Index 0 is the head (oldest).
// Assumes reorder_i is raised only with a valid index (< count) and that
// push/pop are not applied in a reorder cycle (reorder wins).
module rhp_queue #(
    parameter int DEPTH  = 16,
    parameter int RANK_W = 1,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [RANK_W-1:0] push_rank_i,
    input  logic [BANK_W-1:0] push_bank_i,
    input  logic [ROW_W-1:0]  push_row_i,
    input  logic              pop_i,
    input  logic              reorder_i,
    input  logic [IDX_W-1:0]  reorder_idx_i,
    output logic [RANK_W-1:0] q_rank_o [DEPTH],
    output logic [BANK_W-1:0] q_bank_o [DEPTH],
    output logic [ROW_W-1:0]  q_row_o  [DEPTH],
    output logic [CNT_W-1:0]  count_o
);
    logic [RANK_W-1:0] rank_q [DEPTH];
    logic [BANK_W-1:0] bank_q [DEPTH];
    logic [ROW_W-1:0]  row_q  [DEPTH];
    logic [CNT_W-1:0]  cnt_q, base, nxt_cnt;
    logic              pop_ok, push_ok;
    logic [IDX_W-1:0]  wr_idx;

    // Decide the effect of push and pop on count and write slot.
    always_comb begin
        pop_ok  = pop_i && (cnt_q != '0);
        base    = pop_ok ? cnt_q - 1'b1 : cnt_q;
        push_ok = push_i && (base < CNT_W'(DEPTH));
        wr_idx  = IDX_W'(base);
        nxt_cnt = base + CNT_W'(push_ok);
    end

    // Storage update: reorder, or shift-out plus tail write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int j = 0; j < DEPTH; j++) begin
                rank_q[j] <= '0;
                bank_q[j] <= '0;
                row_q[j]  <= '0;
            end
        end else if (reorder_i) begin
            for (int j = DEPTH - 1; j > 0; j--) begin
                if (j <= int'(reorder_idx_i)) begin
                    rank_q[j] <= rank_q[j-1];
                    bank_q[j] <= bank_q[j-1];
                    row_q[j]  <= row_q[j-1];
                end
            end
            rank_q[0] <= rank_q[reorder_idx_i];
            bank_q[0] <= bank_q[reorder_idx_i];
            row_q[0]  <= row_q[reorder_idx_i];
        end else begin
            if (pop_ok) begin
                for (int j = 0; j < DEPTH - 1; j++) begin
                    rank_q[j] <= rank_q[j+1];
                    bank_q[j] <= bank_q[j+1];
                    row_q[j]  <= row_q[j+1];
                end
            end
            if (push_ok) begin
                rank_q[wr_idx] <= push_rank_i;
                bank_q[wr_idx] <= push_bank_i;
                row_q[wr_idx]  <= push_row_i;
            end
            cnt_q <= nxt_cnt;
        end
    end

    assign q_rank_o = rank_q;
    assign q_bank_o = bank_q;
    assign q_row_o  = row_q;
    assign count_o  = cnt_q;
endmodule

// File: rtl/rhp_bank_table.sv
// Per-bank open-row table with a column-access limit.
// Assumes at most one command per bank per cycle; activate wins otherwise.
module rhp_bank_table #(
    parameter int NB      = 8,
    parameter int ROW_W   = 8,
    parameter int MAX_ACC = 4,
    localparam int BI_W   = $clog2(NB),
    localparam int ACC_W  = $clog2(MAX_ACC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic [BI_W-1:0]  act_bank_i,
    input  logic [ROW_W-1:0] act_row_i,
    input  logic             col_i,
    input  logic [BI_W-1:0]  col_bank_i,
    input  logic             pre_i,
    input  logic [BI_W-1:0]  pre_bank_i,
    output logic [NB-1:0]    open_o,
    output logic [ROW_W-1:0] row_o [NB]
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic [ACC_W-1:0] acc_q;

        // Track open row and column accesses of bank b.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
                acc_q  <= '0;
            end else if (act_i && act_bank_i == BI_W'(b)) begin
                open_q <= 1'b1;
                row_q  <= act_row_i;
                acc_q  <= '0;
            end else if (pre_i && pre_bank_i == BI_W'(b)) begin
                open_q <= 1'b0;
                acc_q  <= '0;
            end else if (col_i && col_bank_i == BI_W'(b) && open_q) begin
                if (int'(acc_q) + 1 >= MAX_ACC) begin
                    open_q <= 1'b0;
                    acc_q  <= '0;
                end else begin
                    acc_q <= acc_q + 1'b1;
                end
            end
        end

        assign open_o[b] = open_q;
        assign row_o[b]  = row_q;
    end
endmodule

// File: rtl/rhp_select.sv
// Combinational three-tier search over the queue, oldest first.
// Assumes the bank index of an entry is {rank, bank}.
module rhp_select
    import rhp_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int NUM_RANKS = 2,
    parameter int NB        = 8,
    parameter int ROW_W     = 8,
    parameter int TIME_W    = 16,
    localparam int RANK_W   = $clog2(NUM_RANKS),
    localparam int BI_W     = $clog2(NB),
    localparam int BANK_W   = BI_W - RANK_W,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]     count_i,
    input  logic [RANK_W-1:0]    q_rank_i [DEPTH],
    input  logic [BANK_W-1:0]    q_bank_i [DEPTH],
    input  logic [ROW_W-1:0]     q_row_i  [DEPTH],
    input  logic [NB-1:0]        open_i,
    input  logic [ROW_W-1:0]     row_i    [NB],
    input  logic [NB*TIME_W-1:0] col_at_i,
    input  logic [NB-1:0]        hide_ok_i,
    input  logic [NUM_RANKS-1:0] rank_ready_i,
    input  logic                 rw_switch_i,
    input  logic [TIME_W-1:0]    now_i,
    input  logic [TIME_W-1:0]    bus_busy_i,
    input  logic [TIME_W-1:0]    t_cas_i,
    input  logic [TIME_W-1:0]    t_switch_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o,
    output pick_kind_e           kind_o
);
    logic [TIME_W:0] sum, bus_term, thr;

    // Column-ready threshold, floored at zero and at the current time.
    always_comb begin
        sum      = {1'b0, bus_busy_i} + (rw_switch_i ? {1'b0, t_switch_i} : '0);
        bus_term = (sum >= {1'b0, t_cas_i}) ? sum - {1'b0, t_cas_i} : '0;
        thr      = (bus_term > {1'b0, now_i}) ? bus_term : {1'b0, now_i};
    end

    // Oldest-to-youngest scan applying the tier rules.
    always_comb begin
        logic            stop, got_hidden, got_prep;
        logic [BI_W-1:0] gb;
        found_o    = 1'b0;
        idx_o      = '0;
        kind_o     = K_NONE;
        stop       = 1'b0;
        got_hidden = 1'b0;
        got_prep   = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            gb = {q_rank_i[i], q_bank_i[i]};
            if (!stop && i < int'(count_i) && rank_ready_i[q_rank_i[i]]) begin
                if (open_i[gb] && row_i[gb] == q_row_i[i]) begin
                    if ({1'b0, col_at_i[int'(gb)*TIME_W +: TIME_W]} <= thr) begin
                        idx_o = IDX_W'(i); kind_o = K_SEAMLESS;
                        found_o = 1'b1; stop = 1'b1;
                    end else if (!got_hidden && !got_prep) begin
                        idx_o = IDX_W'(i); kind_o = K_PREPPED;
                        found_o = 1'b1; got_prep = 1'b1;
                    end
                end else if (!got_hidden) begin
                    if (hide_ok_i[gb]) begin
                        idx_o = IDX_W'(i); kind_o = K_HIDDEN;
                        found_o = 1'b1; got_hidden = 1'b1;
                    end else if (!got_prep) begin
                        idx_o = IDX_W'(i); kind_o = K_MISS;
                        found_o = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rowhit_picker.sv
// Top: request queue, bank table and tiered selection with a registered
// result. Assumes push/pop are not used in a pick cycle (they are ignored).
module rowhit_picker
    import rhp_pkg::*;
#(
    parameter int DEPTH          = 16,
    parameter int NUM_RANKS      = 2,
    parameter int BANKS_PER_RANK = 4,
    parameter int ROW_W          = 8,
    parameter int TIME_W         = 16,
    parameter int MAX_ACC        = 4,
    localparam int RANK_W = $clog2(NUM_RANKS),
    localparam int BANK_W = $clog2(BANKS_PER_RANK),
    localparam int NB     = NUM_RANKS * BANKS_PER_RANK,
    localparam int BI_W   = RANK_W + BANK_W,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic [RANK_W-1:0]    push_rank_i,
    input  logic [BANK_W-1:0]    push_bank_i,
    input  logic [ROW_W-1:0]     push_row_i,
    input  logic                 pop_i,
    input  logic                 pick_i,
    input  logic                 rw_switch_i,
    input  logic [TIME_W-1:0]    now_i,
    input  logic [TIME_W-1:0]    bus_busy_i,
    input  logic [TIME_W-1:0]    t_cas_i,
    input  logic [TIME_W-1:0]    t_switch_i,
    input  logic [NUM_RANKS-1:0] rank_ready_i,
    input  logic [NB*TIME_W-1:0] bank_col_at_i,
    input  logic [NB-1:0]        bank_hide_ok_i,
    input  logic                 act_i,
    input  logic [BI_W-1:0]      act_bank_i,
    input  logic [ROW_W-1:0]     act_row_i,
    input  logic                 col_i,
    input  logic [BI_W-1:0]      col_bank_i,
    input  logic                 pre_i,
    input  logic [BI_W-1:0]      pre_bank_i,
    output logic [CNT_W-1:0]     count_o,
    output logic                 head_valid_o,
    output logic [RANK_W-1:0]    head_rank_o,
    output logic [BANK_W-1:0]    head_bank_o,
    output logic [ROW_W-1:0]     head_row_o,
    output logic                 done_o,
    output logic                 found_o,
    output logic [IDX_W-1:0]     sel_o,
    output logic [2:0]           kind_o
);
    logic [RANK_W-1:0] q_rank [DEPTH];
    logic [BANK_W-1:0] q_bank [DEPTH];
    logic [ROW_W-1:0]  q_row  [DEPTH];
    logic [NB-1:0]     open_v;
    logic [ROW_W-1:0]  open_row [NB];
    logic              s_found;
    logic [IDX_W-1:0]  s_idx;
    pick_kind_e        s_kind;
    logic              done_q, found_q;
    logic [IDX_W-1:0]  sel_q;
    logic [2:0]        kind_q;

    rhp_queue #(.DEPTH(DEPTH), .RANK_W(RANK_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i && !pick_i), .push_rank_i(push_rank_i),
        .push_bank_i(push_bank_i), .push_row_i(push_row_i),
        .pop_i(pop_i && !pick_i),
        .reorder_i(pick_i && s_found), .reorder_idx_i(s_idx),
        .q_rank_o(q_rank), .q_bank_o(q_bank), .q_row_o(q_row), .count_o(count_o)
    );

    rhp_bank_table #(.NB(NB), .ROW_W(ROW_W), .MAX_ACC(MAX_ACC)) u_banks (
        .clk(clk), .rst_n(rst_n),
        .act_i(act_i), .act_bank_i(act_bank_i), .act_row_i(act_row_i),
        .col_i(col_i), .col_bank_i(col_bank_i),
        .pre_i(pre_i), .pre_bank_i(pre_bank_i),
        .open_o(open_v), .row_o(open_row)
    );

    rhp_select #(.DEPTH(DEPTH), .NUM_RANKS(NUM_RANKS), .NB(NB), .ROW_W(ROW_W),
                 .TIME_W(TIME_W)) u_select (
        .count_i(count_o), .q_rank_i(q_rank), .q_bank_i(q_bank), .q_row_i(q_row),
        .open_i(open_v), .row_i(open_row), .col_at_i(bank_col_at_i),
        .hide_ok_i(bank_hide_ok_i), .rank_ready_i(rank_ready_i),
        .rw_switch_i(rw_switch_i), .now_i(now_i), .bus_busy_i(bus_busy_i),
        .t_cas_i(t_cas_i), .t_switch_i(t_switch_i),
        .found_o(s_found), .idx_o(s_idx), .kind_o(s_kind)
    );

    // Register the pick result and hold it until the next pick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            found_q <= 1'b0;
            sel_q   <= '0;
            kind_q  <= '0;
        end else begin
            done_q <= pick_i;
            if (pick_i) begin
                found_q <= s_found;
                sel_q   <= s_idx;
                kind_q  <= s_kind;
            end
        end
    end

    assign done_o       = done_q;
    assign found_o      = found_q;
    assign sel_o        = sel_q;
    assign kind_o       = kind_q;
    assign head_valid_o = (count_o != '0);
    assign head_rank_o  = q_rank[0];
    assign head_bank_o  = q_bank[0];
    assign head_row_o   = q_row[0];
endmodule

// File: rtl/rhp_checker.sv
// Temporal checks on the picker's ports; attached by bind below.
module rhp_checker #(
    parameter int DEPTH  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic             pop_i,
    input logic             pick_i,
    input logic [CNT_W-1:0] count_o,
    input logic             done_o,
    input logic             found_o,
    input logic [IDX_W-1:0] sel_o,
    input logic [2:0]       kind_o
);
    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));
    // R2
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !pick_i && count_o == CNT_W'(DEPTH)) |=> count_o == CNT_W'(DEPTH));
    // R10
    pick_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_i |=> count_o == $past(count_o));
    // R5
    empty_pick_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_i && count_o == '0) |=> !found_o);
    // R10
    sel_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && found_o) |-> sel_o < IDX_W'(count_o) || count_o == CNT_W'(DEPTH));
    // R12
    kind_matches_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (found_o == (kind_o != 3'd0)));
    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_i |=> ($stable(found_o) && $stable(sel_o) && $stable(kind_o) && !done_o));
endmodule

bind rowhit_picker rhp_checker #(.DEPTH(DEPTH)) u_rhp_checker (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pick_i(pick_i),
    .count_o(count_o), .done_o(done_o), .found_o(found_o), .sel_o(sel_o),
    .kind_o(kind_o)
);

// File: tb/rowhit_picker_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module rowhit_picker_bench;
    localparam int DEPTH = 16;
    localparam int NR = 2, BPR = 4, NB = 8, ROW_W = 8, TW = 16, MAX_ACC = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic push_i = 0, pop_i = 0, pick_i = 0, rw_switch_i = 0;
    logic [0:0] push_rank_i = '0;
    logic [1:0] push_bank_i = '0;
    logic [ROW_W-1:0] push_row_i = '0;
    logic [TW-1:0] now_i = 16'd10, bus_busy_i = 16'd20, t_cas_i = 16'd5, t_switch_i = 16'd3;
    logic [NR-1:0] rank_ready_i = 2'b11;
    logic [NB*TW-1:0] col_at = '0;
    logic [NB-1:0] hide_ok = '0;
    logic act_i = 0, col_i = 0, pre_i = 0;
    logic [2:0] act_bank_i = '0, col_bank_i = '0, pre_bank_i = '0;
    logic [ROW_W-1:0] act_row_i = '0;
    logic [4:0] count_o;
    logic head_valid_o, done_o, found_o;
    logic [0:0] head_rank_o;
    logic [1:0] head_bank_o;
    logic [ROW_W-1:0] head_row_o;
    logic [3:0] sel_o;
    logic [2:0] kind_o;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    rowhit_picker #(.DEPTH(DEPTH), .NUM_RANKS(NR), .BANKS_PER_RANK(BPR), .ROW_W(ROW_W),
                    .TIME_W(TW), .MAX_ACC(MAX_ACC)) u_rowhit_picker (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_rank_i(push_rank_i),
        .push_bank_i(push_bank_i), .push_row_i(push_row_i), .pop_i(pop_i),
        .pick_i(pick_i), .rw_switch_i(rw_switch_i), .now_i(now_i),
        .bus_busy_i(bus_busy_i), .t_cas_i(t_cas_i), .t_switch_i(t_switch_i),
        .rank_ready_i(rank_ready_i), .bank_col_at_i(col_at), .bank_hide_ok_i(hide_ok),
        .act_i(act_i), .act_bank_i(act_bank_i), .act_row_i(act_row_i),
        .col_i(col_i), .col_bank_i(col_bank_i), .pre_i(pre_i), .pre_bank_i(pre_bank_i),
        .count_o(count_o), .head_valid_o(head_valid_o), .head_rank_o(head_rank_o),
        .head_bank_o(head_bank_o), .head_row_o(head_row_o), .done_o(done_o),
        .found_o(found_o), .sel_o(sel_o), .kind_o(kind_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int r, int b, int row);
        push_i = 1; push_rank_i = 1'(r); push_bank_i = 2'(b); push_row_i = 8'(row);
        tick();
        push_i = 0;
    endtask

    task automatic pop_all();
        while (count_o != 0) begin
            pop_i = 1; tick(); pop_i = 0;
        end
    endtask

    task automatic activate(int gb, int row);
        act_i = 1; act_bank_i = 3'(gb); act_row_i = 8'(row); tick(); act_i = 0;
    endtask

    task automatic column(int gb);
        col_i = 1; col_bank_i = 3'(gb); tick(); col_i = 0;
    endtask

    task automatic precharge(int gb);
        pre_i = 1; pre_bank_i = 3'(gb); tick(); pre_i = 0;
    endtask

    task automatic set_col(int gb, int v);
        col_at[gb*TW +: TW] = 16'(v);
    endtask

    // One pick; compares the registered result one cycle later.
    task automatic pick_expect(string req, int f, int idx, int kind);
        pick_i = 1; tick(); pick_i = 0;
        chk(req, "done", int'(done_o), 1);
        chk(req, "found", int'(found_o), f);
        if (f != 0) chk(req, "sel", int'(sel_o), idx);
        chk(req, "kind", int'(kind_o), kind);
    endtask

    task automatic t_reset();
        chk("R1", "count", int'(count_o), 0);
        chk("R1", "head_valid", int'(head_valid_o), 0);
        chk("R1", "done", int'(done_o), 0);
        chk("R1", "found", int'(found_o), 0);
        chk("R1", "kind", int'(kind_o), 0);
    endtask

    task automatic t_queue();
        push(0, 2, 1); push(0, 2, 2); push(0, 2, 3);
        chk("R2", "count after 3 pushes", int'(count_o), 3);
        chk("R2", "head row", int'(head_row_o), 1);
        pop_i = 1; tick(); pop_i = 0;
        chk("R2", "head row after pop", int'(head_row_o), 2);
        chk("R2", "count after pop", int'(count_o), 2);
        pop_all();
        for (int i = 0; i < DEPTH; i++) push(0, 2, i);
        push(0, 2, 99);
        chk("R2", "count when full", int'(count_o), DEPTH);
        for (int i = 0; i < DEPTH - 1; i++) begin
            pop_i = 1; tick(); pop_i = 0;
        end
        chk("R2", "last row kept, overflow dropped", int'(head_row_o), DEPTH - 1);
        pop_all();
    endtask

    task automatic t_empty();
        pick_expect("R5", 0, 0, 0);
    endtask

    task automatic t_seamless();
        activate(0, 5); activate(1, 7);
        set_col(0, 30); set_col(1, 10); hide_ok = 8'b0000_0100;
        push(0, 0, 5); push(0, 2, 9); push(0, 1, 7); push(0, 3, 4);
        pick_expect("R6", 1, 2, 1);
        chk("R10", "count after pick", int'(count_o), 4);
        chk("R10", "head after pick", int'(head_row_o), 7);
        pop_i = 1; tick(); pop_i = 0;
        chk("R10", "second entry", int'(head_row_o), 5);
        pop_i = 1; tick(); pop_i = 0;
        chk("R10", "third entry", int'(head_row_o), 9);
        pop_i = 1; tick(); pop_i = 0;
        chk("R10", "fourth entry", int'(head_row_o), 4);
        pop_all();
        hide_ok = '0;
    endtask

    task automatic t_hidden();
        hide_ok = 8'b0000_1000;
        push(0, 0, 5); push(0, 2, 9); push(0, 3, 11); push(0, 3, 12);
        pick_expect("R7", 1, 2, 2);
        pop_all();
        hide_ok = '0;
    endtask

    task automatic t_prepped();
        push(0, 2, 1); push(0, 0, 5); push(0, 2, 12);
        pick_expect("R8", 1, 1, 3);
        pop_all();
    endtask

    task automatic t_youngest();
        push(0, 2, 1); push(0, 2, 2); push(0, 3, 3);
        pick_expect("R9", 1, 2, 4);
        pop_all();
    endtask

    task automatic t_rank();
        activate(4, 0); set_col(4, 0);
        rank_ready_i = 2'b01;
        push(1, 0, 0); push(1, 0, 0);
        pick_expect("R5", 0, 0, 0);
        rank_ready_i = 2'b11;
        pick_expect("R5", 1, 0, 1);
        pop_all();
    endtask

    task automatic t_threshold();
        push(0, 1, 7);
        set_col(1, 15);
        pick_expect("R3", 1, 0, 1);
        tick();
        chk("R12", "done drops", int'(done_o), 0);
        chk("R12", "kind held", int'(kind_o), 1);
        set_col(1, 16);
        pick_expect("R3", 1, 0, 3);
        rw_switch_i = 1;
        pick_expect("R4", 1, 0, 1);
        set_col(1, 19);
        pick_expect("R4", 1, 0, 3);
        rw_switch_i = 0;
        bus_busy_i = 16'd2; now_i = 16'd0; set_col(1, 0);
        pick_expect("R3", 1, 0, 1);
        set_col(1, 1);
        pick_expect("R3", 1, 0, 3);
        bus_busy_i = 16'd10; now_i = 16'd12; set_col(1, 12);
        pick_expect("R3", 1, 0, 1);
        set_col(1, 13);
        pick_expect("R3", 1, 0, 3);
        bus_busy_i = 16'd20; now_i = 16'd10;
        pop_all();
    endtask

    task automatic t_close();
        activate(1, 7); set_col(1, 0); hide_ok = 8'b0000_0010;
        push(0, 1, 7);
        for (int i = 0; i < MAX_ACC - 1; i++) column(1);
        pick_expect("R11", 1, 0, 1);
        column(1);
        pick_expect("R11", 1, 0, 2);
        activate(1, 7);
        pick_expect("R11", 1, 0, 1);
        precharge(1);
        pick_expect("R11", 1, 0, 2);
        hide_ok = '0;
        pop_all();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_queue();
        t_empty();
        t_seamless();
        t_hidden();
        t_prepped();
        t_youngest();
        t_rank();
        t_threshold();
        t_close();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule